// File: doc/BRIEF.md
# Receiver Power-State and Bus-Mode Controller

This block tracks the power condition of a serially programmed radio receiver. An active-low reset pin holds it dormant. When the pin is released, the block samples four strap pins once to fix the control-bus mode, and then it follows register writes that carry a power-up bit and a power-down bit. A power-up request passes only when the supplies are reported good, the reference clock is present and the oscillator has had time to settle. A failed request sets an error flag that stays set. A combined power-up plus power-down write starts a timed shutdown. When the shutdown ends, the block drops the power-up bit by itself and pulses a strobe that zeroes the broadcast-data register.

The block exchanges no data stream, so there is no valid/ready handshake anywhere. Every input is a plain level or a single-cycle strobe sampled on the rising clock edge. `cfg_wr` is a one-cycle write strobe, and there is no back-pressure: a write that arrives in a state that ignores it is dropped. Every output is registered or decoded from registered state.

Top module: `tuner_pwr_ctrl`

## Requirements
- R1: While `pin_rst_n` is sampled low, the next state is Inactive (`pwr_state`=0), `bus_mode` is 0 and the error flag is cleared. `reg_reset` is high for exactly the one cycle after the block enters Inactive from any other state.
- R2: At the first edge where Inactive sees `pin_rst_n` high, the state becomes Powerdown (1). `bus_active` is 1 in every state except Inactive, but only while the mode is 2-wire or 3-wire.
- R3: The mode is latched on that release and then held until the next reset. Encodings are 01 = 2-wire, 10 = 3-wire and 11 = invalid. If `strap_gpio3`=1, the mode is 3-wire when `strap_gpio1`=1 and 2-wire otherwise. If `strap_gpio3`=0, `strap_sen_n`=0 with `strap_sdio`=1 gives 3-wire, `strap_sen_n`=1 with `strap_sdio`=0 gives 2-wire, and any other pattern gives invalid.
- R4: A write of enable=1, disable=0 in Powerdown or Partial moves the state to Powerup (2), provided the request is accepted.
- R5: Read-back values are 0/0 in Inactive and in Powerdown, 1/0 in Powerup, and 1/1 while a shutdown is running.
- R6: A write with enable=0 in Powerup (with no shutdown running) enters Partial (3). In Partial, `rd_enable` is 0 and `rd_disable` shows the disable bit of that write.
- R7: A write of enable=1, disable=1 in Powerup raises `pd_busy`. Exactly PD_CYCLES edges later the state is Powerdown. Writes made during the shutdown are ignored.
- R8: `rdsd_clear` is high for exactly one cycle, the first cycle in Powerdown after a shutdown completes, and at no other time.
- R9: A power-up request with `supply_ok` or `clk_present` low is rejected, and the state does not change. The rejection sets `en_reject_err`, which stays set until `pin_rst_n` goes low.
- R10: While `osc_en` is 1, a power-up request is rejected until `osc_en` has been sampled high on SETTLE_CYCLES edges. While `osc_en` is 0, no settling is needed.
- R11: Writes are ignored in Inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Block reset, active low |
| pin_rst_n | input | 1 | Receiver reset pin, active low |
| strap_sen_n | input | 1 | Strap: serial-enable pin level |
| strap_sdio | input | 1 | Strap: data pin level |
| strap_gpio1 | input | 1 | Strap: general pin 1 level |
| strap_gpio3 | input | 1 | Strap: general pin 3 level |
| osc_en | input | 1 | Internal oscillator enable bit |
| supply_ok | input | 1 | Analog and digital supplies present |
| clk_present | input | 1 | Reference clock present |
| cfg_wr | input | 1 | One-cycle power register write strobe |
| cfg_enable | input | 1 | Written power-up bit |
| cfg_disable | input | 1 | Written power-down bit |
| pwr_state | output | 2 | 0 Inactive, 1 Powerdown, 2 Powerup, 3 Partial |
| rd_enable | output | 1 | Read-back of power-up bit |
| rd_disable | output | 1 | Read-back of power-down bit |
| bus_mode | output | 2 | Latched control-bus mode |
| bus_active | output | 1 | Control bus usable |
| reg_reset | output | 1 | Register-file default pulse |
| rdsd_clear | output | 1 | Broadcast-data register clear strobe |
| en_reject_err | output | 1 | Sticky rejected power-up flag |
| pd_busy | output | 1 | Shutdown sequence running |

## Verification
The bench targets the shutdown count. A counter that is off by one moves the Powerdown entry and the clear strobe by a cycle, and a counter that accepts writes while busy lands in Partial. It checks that the straps are latched only once, because a design that re-samples them would change the mode after straps move in Powerdown. It also drives power-up requests with each gating condition missing in turn and with the oscillator still settling. A design that lost the sticky error or skipped a condition would either power up or clear the flag.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    PS_INACTIVE = 2'd0,
    PS_DOWN     = 2'd1,
    PS_UP       = 2'd2,
    PS_PARTIAL  = 2'd3
  } pstate_t;

  typedef enum logic [1:0] {
    BM_NONE  = 2'b00,
    BM_TWO   = 2'b01,
    BM_THREE = 2'b10,
    BM_BAD   = 2'b11
  } bmode_t;
endpackage

// File: rtl/tpc_busmode.sv
module tpc_busmode
  import tpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_rst_n,
  input  logic   latch_en,
  input  logic   sen_n,
  input  logic   sdio,
  input  logic   gpio1,
  input  logic   gpio3,
  output bmode_t mode
);
  bmode_t decoded;

  always_comb begin
    if (gpio3) begin
      decoded = gpio1 ? BM_THREE : BM_TWO;
    end else if (!sen_n && sdio) begin
      decoded = BM_THREE;
    end else if (sen_n && !sdio) begin
      decoded = BM_TWO;
    end else begin
      decoded = BM_BAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= BM_NONE;
    end else if (!pin_rst_n) begin
      mode <= BM_NONE;
    end else if (latch_en) begin
      mode <= decoded;
    end
  end
endmodule

// File: rtl/tpc_settle.sv
module tpc_settle #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_n,
  input  logic osc_en,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  assign settled = !osc_en || (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!pin_rst_n || !osc_en) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tpc_fsm.sv
module tpc_fsm
  import tpc_pkg::*;
#(
  parameter int PD_CYCLES = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_rst_n,
  input  logic    cfg_wr,
  input  logic    cfg_enable,
  input  logic    cfg_disable,
  input  logic    start_ok,
  output pstate_t state,
  output logic    rd_en,
  output logic    rd_dis,
  output logic    busy,
  output logic    latch_mode,
  output logic    reg_reset,
  output logic    rdsd_clear,
  output logic    err
);
  localparam int PW = $clog2(PD_CYCLES + 1);
  localparam logic [PW-1:0] PD_LOAD = PW'(PD_CYCLES);

  pstate_t       st_q;
  logic [PW-1:0] pd_cnt_q;
  logic          pdis_q;
  logic          err_q;
  logic          rr_q;
  logic          rc_q;
  logic          up_req;

  assign up_req     = cfg_wr && cfg_enable && !cfg_disable;
  assign busy       = (pd_cnt_q != '0);
  assign latch_mode = (st_q == PS_INACTIVE) && pin_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_INACTIVE;
      pd_cnt_q <= '0;
      pdis_q   <= 1'b0;
      err_q    <= 1'b0;
      rr_q     <= 1'b0;
      rc_q     <= 1'b0;
    end else if (!pin_rst_n) begin
      rr_q     <= (st_q != PS_INACTIVE);
      st_q     <= PS_INACTIVE;
      pd_cnt_q <= '0;
      pdis_q   <= 1'b0;
      err_q    <= 1'b0;
      rc_q     <= 1'b0;
    end else begin
      rr_q <= 1'b0;
      rc_q <= 1'b0;
      unique case (st_q)
        PS_INACTIVE: st_q <= PS_DOWN;
        PS_DOWN, PS_PARTIAL: begin
          if (up_req) begin
            if (start_ok) st_q <= PS_UP;
            else          err_q <= 1'b1;
          end
        end
        PS_UP: begin
          if (busy) begin
            if (pd_cnt_q == PW'(1)) begin
              st_q <= PS_DOWN;
              rc_q <= 1'b1;
            end
            pd_cnt_q <= pd_cnt_q - 1'b1;
          end else if (cfg_wr) begin
            if (!cfg_enable) begin
              st_q   <= PS_PARTIAL;
              pdis_q <= cfg_disable;
            end else if (cfg_disable) begin
              pd_cnt_q <= PD_LOAD;
            end
          end
        end
        default: st_q <= PS_INACTIVE;
      endcase
    end
  end

  always_comb begin
    rd_en  = 1'b0;
    rd_dis = 1'b0;
    if (st_q == PS_UP) begin
      rd_en  = 1'b1;
      rd_dis = busy;
    end else if (st_q == PS_PARTIAL) begin
      rd_dis = pdis_q;
    end
  end

  assign state      = st_q;
  assign reg_reset  = rr_q;
  assign rdsd_clear = rc_q;
  assign err        = err_q;
endmodule

// File: rtl/tuner_pwr_ctrl.sv
module tuner_pwr_ctrl
  import tpc_pkg::*;
#(
  parameter int PD_CYCLES     = 16,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_rst_n,
  input  logic       strap_sen_n,
  input  logic       strap_sdio,
  input  logic       strap_gpio1,
  input  logic       strap_gpio3,
  input  logic       osc_en,
  input  logic       supply_ok,
  input  logic       clk_present,
  input  logic       cfg_wr,
  input  logic       cfg_enable,
  input  logic       cfg_disable,
  output logic [1:0] pwr_state,
  output logic       rd_enable,
  output logic       rd_disable,
  output logic [1:0] bus_mode,
  output logic       bus_active,
  output logic       reg_reset,
  output logic       rdsd_clear,
  output logic       en_reject_err,
  output logic       pd_busy
);
  pstate_t st;
  bmode_t  mode;
  logic    settled;
  logic    latch_mode;
  logic    start_ok;

  assign start_ok = supply_ok && clk_present && settled;

  tpc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n),
    .osc_en(osc_en), .settled(settled)
  );

  tpc_fsm #(.PD_CYCLES(PD_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n),
    .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
    .start_ok(start_ok), .state(st), .rd_en(rd_enable), .rd_dis(rd_disable),
    .busy(pd_busy), .latch_mode(latch_mode), .reg_reset(reg_reset),
    .rdsd_clear(rdsd_clear), .err(en_reject_err)
  );

  tpc_busmode u_mode (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .latch_en(latch_mode),
    .sen_n(strap_sen_n), .sdio(strap_sdio), .gpio1(strap_gpio1),
    .gpio3(strap_gpio3), .mode(mode)
  );

  assign pwr_state  = st;
  assign bus_mode   = mode;
  assign bus_active = (st != PS_INACTIVE) && ((mode == BM_TWO) || (mode == BM_THREE));
endmodule

// File: rtl/tuner_pwr_ctrl_chk.sv
module tuner_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_rst_n,
  input logic       supply_ok,
  input logic       cfg_wr,
  input logic       cfg_enable,
  input logic       cfg_disable,
  input logic [1:0] pwr_state,
  input logic [1:0] bus_mode,
  input logic       bus_active,
  input logic       reg_reset,
  input logic       rdsd_clear,
  input logic       en_reject_err,
  input logic       pd_busy
);
  AST_PIN_LOW_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rst_n |=> pwr_state == 2'd0); // R1
  AST_REGRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset |=> !reg_reset); // R1
  AST_RELEASE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && pin_rst_n) |=> pwr_state == 2'd1); // R2
  AST_NO_BUS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd0 |-> !bus_active); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0 && pin_rst_n) |=> $stable(bus_mode)); // R3
  AST_BUSY_ONLY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    pd_busy |-> pwr_state == 2'd2); // R7
  AST_CLEAR_AFTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdsd_clear) |-> (pwr_state == 2'd1 && $past(pd_busy))); // R8
  AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rst_n && pwr_state == 2'd1 && cfg_wr && cfg_enable && !cfg_disable && !supply_ok)
      |=> (en_reject_err && pwr_state == 2'd1)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_reject_err && pin_rst_n) |=> en_reject_err); // R9
endmodule

bind tuner_pwr_ctrl tuner_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .supply_ok(supply_ok),
  .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
  .pwr_state(pwr_state), .bus_mode(bus_mode), .bus_active(bus_active),
  .reg_reset(reg_reset), .rdsd_clear(rdsd_clear),
  .en_reject_err(en_reject_err), .pd_busy(pd_busy)
);

// File: tb/tuner_pwr_ctrl_tb_top.sv
module tuner_pwr_ctrl_tb_top;
  localparam int PD = 16;
  localparam int ST = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_rst_n = 1'b0;
  logic strap_sen_n = 1'b0, strap_sdio = 1'b1, strap_gpio1 = 1'b0, strap_gpio3 = 1'b0;
  logic osc_en = 1'b0, supply_ok = 1'b1, clk_present = 1'b1;
  logic cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_disable = 1'b0;
  logic [1:0] pwr_state, bus_mode;
  logic rd_enable, rd_disable, bus_active, reg_reset, rdsd_clear, en_reject_err, pd_busy;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tuner_pwr_ctrl #(.PD_CYCLES(PD), .SETTLE_CYCLES(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n),
    .strap_sen_n(strap_sen_n), .strap_sdio(strap_sdio),
    .strap_gpio1(strap_gpio1), .strap_gpio3(strap_gpio3),
    .osc_en(osc_en), .supply_ok(supply_ok), .clk_present(clk_present),
    .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
    .pwr_state(pwr_state), .rd_enable(rd_enable), .rd_disable(rd_disable),
    .bus_mode(bus_mode), .bus_active(bus_active), .reg_reset(reg_reset),
    .rdsd_clear(rdsd_clear), .en_reject_err(en_reject_err), .pd_busy(pd_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_state = 0, m_cnt = 0, m_pdis = 0, m_err = 0, m_rr = 0, m_rc = 0, m_mode = 0, m_sc = 0;

  function automatic int strap_mode(input bit s, input bit d, input bit g1, input bit g3);
    if (g3) return g1 ? 2 : 1;
    if (!s && d) return 2;
    if (s && !d) return 1;
    return 3;
  endfunction

  always @(posedge clk) begin
    bit ok;
    ok = supply_ok && clk_present && (!osc_en || m_sc >= ST);
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_pdis = 0; m_err = 0; m_rr = 0; m_rc = 0; m_mode = 0; m_sc = 0;
    end else if (!pin_rst_n) begin
      m_rr = (m_state != 0) ? 1 : 0;
      m_state = 0; m_cnt = 0; m_pdis = 0; m_err = 0; m_rc = 0; m_mode = 0; m_sc = 0;
    end else begin
      m_rr = 0; m_rc = 0;
      if (m_state == 0) begin
        m_state = 1;
        m_mode = strap_mode(strap_sen_n, strap_sdio, strap_gpio1, strap_gpio3);
      end else if (m_state == 1 || m_state == 3) begin
        if (cfg_wr && cfg_enable && !cfg_disable) begin
          if (ok) m_state = 2; else m_err = 1;
        end
      end else if (m_cnt > 0) begin
        if (m_cnt == 1) begin m_state = 1; m_rc = 1; end
        m_cnt--;
      end else if (cfg_wr) begin
        if (!cfg_enable) begin m_state = 3; m_pdis = cfg_disable; end
        else if (cfg_disable) m_cnt = PD;
      end
      m_sc = osc_en ? ((m_sc < ST) ? m_sc + 1 : ST) : 0;
    end
    #5;
    chk("R4 pwr_state", pwr_state, m_state);
    chk("R5 rd_enable", rd_enable, (m_state == 2) ? 1 : 0);
    chk("R5 rd_disable", rd_disable,
        (m_state == 2) ? ((m_cnt > 0) ? 1 : 0) : ((m_state == 3) ? m_pdis : 0));
    chk("R3 bus_mode", bus_mode, m_mode);
    chk("R2 bus_active", bus_active, (m_state != 0 && (m_mode == 1 || m_mode == 2)) ? 1 : 0);
    chk("R1 reg_reset", reg_reset, m_rr);
    chk("R8 rdsd_clear", rdsd_clear, m_rc);
    chk("R9 en_reject_err", en_reject_err, m_err);
    chk("R7 pd_busy", pd_busy, (m_cnt > 0) ? 1 : 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit en, input bit dis);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_enable = en; cfg_disable = dis;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_enable = 1'b0; cfg_disable = 1'b0;
  endtask

  task automatic pin_cycle();
    @(negedge clk); pin_rst_n = 1'b0;
    cyc(3);
    pin_rst_n = 1'b1;
    cyc(2);
  endtask

  bit done = 1'b0;

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 inactive", pwr_state, 0);
    chk("R1 bus off", bus_active, 0);
    pin_rst_n = 1'b1;
    cyc(2);
    chk("R2 powerdown", pwr_state, 1);
    chk("R3 three-wire", bus_mode, 2);
    strap_sen_n = 1'b1; strap_sdio = 1'b0;
    cyc(2);
    chk("R3 mode held", bus_mode, 2);
    supply_ok = 1'b0;
    wr(1, 0);
    chk("R9 rejected state", pwr_state, 1);
    chk("R9 error set", en_reject_err, 1);
    supply_ok = 1'b1;
    wr(1, 0);
    chk("R4 powerup", pwr_state, 2);
    chk("R9 sticky", en_reject_err, 1);
    chk("R5 rd_enable up", rd_enable, 1);
    wr(1, 1);
    chk("R7 busy", pd_busy, 1);
    chk("R5 rd_disable busy", rd_disable, 1);
    wr(0, 0);
    chk("R7 write ignored", pwr_state, 2);
    cyc(PD);
    chk("R7 back to powerdown", pwr_state, 1);
    chk("R5 enable cleared", rd_enable, 0);
    wr(1, 0);
    wr(0, 1);
    chk("R6 partial", pwr_state, 3);
    chk("R6 dis readback", rd_disable, 1);
    chk("R6 en readback", rd_enable, 0);
    wr(1, 0);
    chk("R4 partial to up", pwr_state, 2);
    @(negedge clk); pin_rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reg_reset pulse", reg_reset, 1);
    chk("R1 error cleared", en_reject_err, 0);
    wr(1, 0);
    chk("R11 write in inactive", pwr_state, 0);
    chk("R11 enable stays 0", rd_enable, 0);
    strap_gpio3 = 1'b1; strap_gpio1 = 1'b0;
    pin_rst_n = 1'b1;
    cyc(2);
    chk("R3 gpio two-wire", bus_mode, 1);
    osc_en = 1'b1;
    cyc(2);
    wr(1, 0);
    chk("R10 still settling", pwr_state, 1);
    chk("R10 err", en_reject_err, 1);
    cyc(ST);
    wr(1, 0);
    chk("R10 settled accept", pwr_state, 2);
    osc_en = 1'b0;
    strap_gpio1 = 1'b1;
    pin_cycle();
    chk("R3 gpio three-wire", bus_mode, 2);
    clk_present = 1'b0;
    wr(1, 0);
    chk("R9 no clock", pwr_state, 1);
    clk_present = 1'b1;
    strap_gpio3 = 1'b0; strap_sen_n = 1'b0; strap_sdio = 1'b0;
    pin_cycle();
    chk("R3 invalid", bus_mode, 3);
    chk("R2 bus off invalid", bus_active, 0);
    cyc(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule